// File: doc/BRIEF.md
# Shortest-Burst-First Write Arbiter

This block shares one AXI4 write port on the slave side among several masters. Each master brings its own write address, write data and write response channels. The block chooses one requesting master and gives it the slave port for a whole write transaction. That covers the address handshake, every data beat and the response handshake. When the transaction ends, the port passes to the next master.

The order of service is fixed when the design is built. Each master's usual burst length is a parameter. A master with a shorter burst ranks above a master with a longer one. When two lengths are equal, the lower index ranks first. This ordering lowers the average wait of the masters compared with plain index order, because short transactions no longer queue behind long ones.

A master counts as requesting while its AWVALID is high. A master that does not hold the port sees AWREADY, WREADY and BVALID held low. Only the write path is present.

Top module: `burst_wr_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no requests, s_awvalid, s_wvalid and s_bready are low, and every bit of m_awready, m_wready and m_bvalid is low.
- R2: While no master drives AWVALID, the block stays idle. No address, data or response handshake is forwarded and no ready is raised toward any master.
- R3: When several masters request in the same cycle while the block is idle, the master whose configured burst length (MST_LEN slice, beats minus one) is smallest is granted first. The others follow in ascending length order as each transaction ends.
- R4: With the default lengths 15, 7, 3 and 1 (16, 8, 4 and 2 beats) on masters 0 to 3, four simultaneous requests are served in the order 3, 2, 1, 0.
- R5: A granted master keeps the port until its B handshake (s_bvalid and s_bready both high). A request from a higher-ranked master that arrives during the transaction waits.
- R6: At any time at most one master sees AWREADY, WREADY or BVALID high, and only the master that owns the port sees them.
- R7: On the clock edge that completes the B handshake, the highest-ranked pending master is granted. Its address handshake can complete on the next edge. If nothing is pending, the block returns to idle.
- R8: Exactly one address is forwarded per grant. After the address handshake, s_awvalid and the owner's AWREADY stay low until the grant ends, even if the owner holds AWVALID high.
- R9: The slave port carries the owner's AWADDR, AWLEN, WDATA, WSTRB and WLAST. The owner receives the slave's BRESP on its own m_bresp slice (bits 2i+1:2i for master i).
- R10: From idle, the grant registers on the first edge after a master raises AWVALID. With a ready slave, the address handshake completes on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_awvalid | input | N_MST | Per-master address valid; also the request |
| m_awready | output | N_MST | Per-master address ready |
| m_awaddr | input | N_MST*ADDR_W | Per-master write address, master i in slice i |
| m_awlen | input | N_MST*LEN_W | Per-master burst length minus one |
| m_wvalid | input | N_MST | Per-master data valid |
| m_wready | output | N_MST | Per-master data ready |
| m_wdata | input | N_MST*DATA_W | Per-master write data |
| m_wstrb | input | N_MST*DATA_W/8 | Per-master byte strobes |
| m_wlast | input | N_MST | Per-master last-beat flag |
| m_bvalid | output | N_MST | Per-master response valid |
| m_bready | input | N_MST | Per-master response ready |
| m_bresp | output | N_MST*2 | Per-master response code |
| s_awvalid | output | 1 | Slave address valid |
| s_awready | input | 1 | Slave address ready |
| s_awaddr | output | ADDR_W | Slave write address |
| s_awlen | output | LEN_W | Slave burst length minus one |
| s_wvalid | output | 1 | Slave data valid |
| s_wready | input | 1 | Slave data ready |
| s_wdata | output | DATA_W | Slave write data |
| s_wstrb | output | DATA_W/8 | Slave byte strobes |
| s_wlast | output | 1 | Slave last-beat flag |
| s_bvalid | input | 1 | Slave response valid |
| s_bready | output | 1 | Slave response ready |
| s_bresp | input | 2 | Slave response code |

## Verification
The bench builds the block with its defaults: four masters, 32-bit data and burst lengths of 16, 8, 4 and 2 beats. At this size every one of the fifteen non-empty sets of simultaneous requesters can be swept. For each set, the bench derives the service order by sorting on length and checks the one-cycle handover between consecutive transactions. A late request from the top-ranked master during the longest burst shows that a transaction is never preempted. A master that holds AWVALID through its own burst shows that only one address is forwarded per grant.

// File: rtl/wr_arb_pkg.sv
package wr_arb_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N_MST = 4,
    parameter int LEN_W = 8,
    parameter logic [N_MST*LEN_W-1:0] MST_LEN = {LEN_W'(1), LEN_W'(3), LEN_W'(7), LEN_W'(15)}
) (
    input  logic [N_MST-1:0] req,
    output logic [N_MST-1:0] win
);
    // Masters that outrank master k: shorter configured burst, or equal burst and lower index.
    function automatic logic [N_MST-1:0] ahead_of(input int k);
        logic [N_MST-1:0] m;
        m = '0;
        for (int j = 0; j < N_MST; j++) begin
            if ((MST_LEN[j*LEN_W +: LEN_W] < MST_LEN[k*LEN_W +: LEN_W]) ||
                ((MST_LEN[j*LEN_W +: LEN_W] == MST_LEN[k*LEN_W +: LEN_W]) && (j < k)))
                m[j] = 1'b1;
        end
        return m;
    endfunction

    for (genvar i = 0; i < N_MST; i++) begin : g_rank
        localparam logic [N_MST-1:0] AHEAD = ahead_of(i);
        assign win[i] = req[i] & ~(|(req & AHEAD));
    end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import wr_arb_pkg::*;
#(
    parameter int N_MST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] win,
    input  logic             done,
    output logic [N_MST-1:0] gnt,
    output logic             busy
);
    typedef struct packed {
        arb_state_e       st;
        logic [N_MST-1:0] gnt;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ARB_IDLE: begin
                if (|req) begin
                    r_d.st  = ARB_BUSY;
                    r_d.gnt = win;
                end
            end
            ARB_BUSY: begin
                if (done) begin
                    if (|req) begin
                        r_d.gnt = win;
                    end else begin
                        r_d.st  = ARB_IDLE;
                        r_d.gnt = '0;
                    end
                end
            end
            default: r_d = '{st: ARB_IDLE, gnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ARB_IDLE, gnt: '0};
        else        r_q <= r_d;
    end

    assign gnt  = r_q.gnt;
    assign busy = (r_q.st == ARB_BUSY);

    // R5: ownership is frozen until the response handshake
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(gnt)));
    // R7: with nothing pending at completion the arbiter goes idle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && !(|req)) |=> !busy);
    // R2: idle without requests stays idle
    a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(|req)) |=> (!busy && (gnt == '0)));
    // R10: a request seen in idle is granted on the next edge
    a_r10_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (|req)) |=> (busy && ($countones(gnt) == 1)));
endmodule

// File: rtl/wr_chan_mux.sv
module wr_chan_mux #(
    parameter int N_MST  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_MST-1:0]          gnt,
    input  logic                      busy,
    input  logic                      done,
    input  logic [N_MST-1:0]          m_awvalid,
    output logic [N_MST-1:0]          m_awready,
    input  logic [N_MST*ADDR_W-1:0]   m_awaddr,
    input  logic [N_MST*LEN_W-1:0]    m_awlen,
    input  logic [N_MST-1:0]          m_wvalid,
    output logic [N_MST-1:0]          m_wready,
    input  logic [N_MST*DATA_W-1:0]   m_wdata,
    input  logic [N_MST*STRB_W-1:0]   m_wstrb,
    input  logic [N_MST-1:0]          m_wlast,
    output logic [N_MST-1:0]          m_bvalid,
    input  logic [N_MST-1:0]          m_bready,
    output logic [N_MST*2-1:0]        m_bresp,
    output logic                      s_awvalid,
    input  logic                      s_awready,
    output logic [ADDR_W-1:0]         s_awaddr,
    output logic [LEN_W-1:0]          s_awlen,
    output logic                      s_wvalid,
    input  logic                      s_wready,
    output logic [DATA_W-1:0]         s_wdata,
    output logic [STRB_W-1:0]         s_wstrb,
    output logic                      s_wlast,
    input  logic                      s_bvalid,
    output logic                      s_bready,
    input  logic [1:0]                s_bresp
);
    typedef struct packed {
        logic aw_done;
    } mux_t;

    mux_t r_d, r_q;
    logic aw_open;

    assign aw_open = busy & ~r_q.aw_done;

    always_comb begin
        s_awaddr = '0;
        s_awlen  = '0;
        s_wdata  = '0;
        s_wstrb  = '0;
        s_wlast  = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (gnt[i]) begin
                s_awaddr = m_awaddr[i*ADDR_W +: ADDR_W];
                s_awlen  = m_awlen[i*LEN_W +: LEN_W];
                s_wdata  = m_wdata[i*DATA_W +: DATA_W];
                s_wstrb  = m_wstrb[i*STRB_W +: STRB_W];
                s_wlast  = m_wlast[i];
            end
        end
    end

    assign s_awvalid = aw_open & (|(gnt & m_awvalid));
    assign s_wvalid  = busy & (|(gnt & m_wvalid));
    assign s_bready  = busy & (|(gnt & m_bready));

    assign m_awready = gnt & {N_MST{aw_open & s_awready}};
    assign m_wready  = gnt & {N_MST{busy & s_wready}};
    assign m_bvalid  = gnt & {N_MST{busy & s_bvalid}};

    for (genvar i = 0; i < N_MST; i++) begin : g_resp
        assign m_bresp[i*2 +: 2] = gnt[i] ? s_bresp : 2'b00;
    end

    always_comb begin
        r_d = r_q;
        if (!busy || done)                 r_d.aw_done = 1'b0;
        else if (s_awvalid && s_awready)   r_d.aw_done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{aw_done: 1'b0};
        else        r_q <= r_d;
    end

    // R8: an accepted address is not forwarded again in the same grant
    a_r8_single_aw: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |=> !s_awvalid);
    // R6: master-side handshake strobes reach at most one master
    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_awready) && $onehot0(m_wready) && $onehot0(m_bvalid));
    // R1: nothing leaves on the slave side without an owner
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!s_awvalid && !s_wvalid && !s_bready));
endmodule

// File: rtl/burst_wr_arbiter.sv
module burst_wr_arbiter #(
    parameter int N_MST  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter logic [N_MST*LEN_W-1:0] MST_LEN = {LEN_W'(1), LEN_W'(3), LEN_W'(7), LEN_W'(15)},
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_MST-1:0]          m_awvalid,
    output logic [N_MST-1:0]          m_awready,
    input  logic [N_MST*ADDR_W-1:0]   m_awaddr,
    input  logic [N_MST*LEN_W-1:0]    m_awlen,
    input  logic [N_MST-1:0]          m_wvalid,
    output logic [N_MST-1:0]          m_wready,
    input  logic [N_MST*DATA_W-1:0]   m_wdata,
    input  logic [N_MST*STRB_W-1:0]   m_wstrb,
    input  logic [N_MST-1:0]          m_wlast,
    output logic [N_MST-1:0]          m_bvalid,
    input  logic [N_MST-1:0]          m_bready,
    output logic [N_MST*2-1:0]        m_bresp,
    output logic                      s_awvalid,
    input  logic                      s_awready,
    output logic [ADDR_W-1:0]         s_awaddr,
    output logic [LEN_W-1:0]          s_awlen,
    output logic                      s_wvalid,
    input  logic                      s_wready,
    output logic [DATA_W-1:0]         s_wdata,
    output logic [STRB_W-1:0]         s_wstrb,
    output logic                      s_wlast,
    input  logic                      s_bvalid,
    output logic                      s_bready,
    input  logic [1:0]                s_bresp
);
    logic [N_MST-1:0] win;
    logic [N_MST-1:0] gnt;
    logic             busy;
    logic             done;

    assign done = s_bvalid & s_bready;

    arb_prio_pick #(
        .N_MST  (N_MST),
        .LEN_W  (LEN_W),
        .MST_LEN(MST_LEN)
    ) u_pick (
        .req(m_awvalid),
        .win(win)
    );

    arb_grant_fsm #(
        .N_MST(N_MST)
    ) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (m_awvalid),
        .win  (win),
        .done (done),
        .gnt  (gnt),
        .busy (busy)
    );

    wr_chan_mux #(
        .N_MST (N_MST),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt      (gnt),
        .busy     (busy),
        .done     (done),
        .m_awvalid(m_awvalid),
        .m_awready(m_awready),
        .m_awaddr (m_awaddr),
        .m_awlen  (m_awlen),
        .m_wvalid (m_wvalid),
        .m_wready (m_wready),
        .m_wdata  (m_wdata),
        .m_wstrb  (m_wstrb),
        .m_wlast  (m_wlast),
        .m_bvalid (m_bvalid),
        .m_bready (m_bready),
        .m_bresp  (m_bresp),
        .s_awvalid(s_awvalid),
        .s_awready(s_awready),
        .s_awaddr (s_awaddr),
        .s_awlen  (s_awlen),
        .s_wvalid (s_wvalid),
        .s_wready (s_wready),
        .s_wdata  (s_wdata),
        .s_wstrb  (s_wstrb),
        .s_wlast  (s_wlast),
        .s_bvalid (s_bvalid),
        .s_bready (s_bready),
        .s_bresp  (s_bresp)
    );

    // R3: any non-empty request set yields exactly one candidate
    a_r3_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_awvalid) |-> ($countones(win) == 1));
    // R5: the owner does not change while its response is outstanding
    a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && !done) |=> $stable(gnt));
endmodule

// File: tb/tb_burst_wr_arbiter.sv
module tb_burst_wr_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int WD_LIMIT = 150000;
    localparam int LEN [N] = '{15, 7, 3, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N-1:0]      m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bvalid, m_bready;
    logic [N*AW-1:0]   m_awaddr;
    logic [N*LW-1:0]   m_awlen;
    logic [N*DW-1:0]   m_wdata;
    logic [N*DW/8-1:0] m_wstrb;
    logic [N*2-1:0]    m_bresp;
    logic              s_awvalid, s_awready, s_wvalid, s_wready, s_wlast, s_bvalid, s_bready;
    logic [AW-1:0]     s_awaddr;
    logic [LW-1:0]     s_awlen;
    logic [DW-1:0]     s_wdata;
    logic [DW/8-1:0]   s_wstrb;
    logic [1:0]        s_bresp;

    logic          awv [N];
    logic [AW-1:0] awa [N];
    logic [LW-1:0] awl [N];
    logic          wv  [N];
    logic [DW-1:0] wd  [N];
    logic          wl  [N];
    logic          bry [N];

    for (genvar g = 0; g < N; g++) begin : g_pack
        assign m_awvalid[g]          = awv[g];
        assign m_awaddr[g*AW +: AW]  = awa[g];
        assign m_awlen[g*LW +: LW]   = awl[g];
        assign m_wvalid[g]           = wv[g];
        assign m_wdata[g*DW +: DW]   = wd[g];
        assign m_wstrb[g*4 +: 4]     = 4'hF;
        assign m_wlast[g]            = wl[g];
        assign m_bready[g]           = bry[g];
    end

    burst_wr_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_wlast(s_wlast), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Responder slave: one transaction at a time, checks routing and WLAST.
    logic       rs_busy = 1'b0;
    logic [LW-1:0] rs_len = '0;
    logic [1:0] rs_id = '0;
    int         rs_cnt = 0;
    int         log_n = 0;
    int         log_id [128];
    int         log_aw [128];
    int         log_b  [128];
    int         r9_err = 0;
    int         r9_n = 0;
    logic       bv = 1'b0;

    assign s_awready = !rs_busy;
    assign s_wready  = rs_busy && !bv;
    assign s_bvalid  = bv;
    assign s_bresp   = rs_id;

    always @(posedge clk) begin
        if (!rst_n) begin
            rs_busy <= 1'b0;
            bv      <= 1'b0;
        end else begin
            if (s_awvalid && s_awready) begin
                rs_busy <= 1'b1;
                rs_len  <= s_awlen;
                rs_id   <= s_awaddr[13:12];
                rs_cnt  <= 0;
                log_id[log_n] <= int'(s_awaddr[13:12]);
                log_aw[log_n] <= cyc;
                log_n <= log_n + 1;
                r9_n <= r9_n + 1;
                if (int'(s_awlen) != LEN[s_awaddr[13:12]] || s_awaddr[11:0] != 12'h0)
                    r9_err <= r9_err + 1;
            end
            if (s_wvalid && s_wready) begin
                rs_cnt <= rs_cnt + 1;
                r9_n <= r9_n + 1;
                if (s_wdata != {6'd0, rs_id, 24'(rs_cnt)} || s_wlast != (rs_cnt == int'(rs_len)) ||
                    s_wstrb != 4'hF)
                    r9_err <= r9_err + 1;
                if (rs_cnt == int'(rs_len)) bv <= 1'b1;
            end
            if (bv && s_bready) begin
                bv      <= 1'b0;
                rs_busy <= 1'b0;
                log_b[log_n-1] <= cyc;
            end
        end
    end

    // R6 monitor: handshake strobes only toward the master that owns the slave side
    int r6_err = 0;
    int r6_n = 0;
    always @(negedge clk) begin
        logic [N-1:0] allowed;
        #2;
        if (rst_n) begin
            allowed = rs_busy ? (N'(1) << rs_id) : '0;
            r6_n <= r6_n + 1;
            if ((m_wready & ~allowed) != 0 || (m_bvalid & ~allowed) != 0 ||
                (rs_busy && m_awready != 0) || !$onehot0(m_awready))
                r6_err <= r6_err + 1;
        end
    end

    int raise_cyc [N];

    task automatic run_master(input int id, input bit hold);
        awv[id] = 1'b1;
        awa[id] = AW'(id) << 12;
        awl[id] = LW'(LEN[id]);
        raise_cyc[id] = cyc;
        #1;
        while (!m_awready[id]) begin @(negedge clk); #1; end
        @(negedge clk);
        if (!hold) awv[id] = 1'b0;
        for (int b = 0; b <= LEN[id]; b++) begin
            wv[id] = 1'b1;
            wd[id] = {6'd0, 2'(id), 24'(b)};
            wl[id] = (b == LEN[id]);
            #1;
            while (!m_wready[id]) begin @(negedge clk); #1; end
            @(negedge clk);
            if (hold) begin
                #1;
                chk(!s_awvalid && !m_awready[id], "R8 second address blocked",
                    {s_awvalid, m_awready[id]}, 0);
            end
        end
        wv[id] = 1'b0;
        wl[id] = 1'b0;
        awv[id] = 1'b0;
        bry[id] = 1'b1;
        #1;
        while (!m_bvalid[id]) begin @(negedge clk); #1; end
        chk(m_bresp[id*2 +: 2] == 2'(id), "R9 response routed", m_bresp[id*2 +: 2], id);
        @(negedge clk);
        bry[id] = 1'b0;
    endtask

    task automatic run_set(input logic [N-1:0] mask);
        int base;
        int cnt;
        logic [N-1:0] taken;
        base = log_n;
        cnt = $countones(mask);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
                fork
                    automatic int k = i;
                    run_master(k, 1'b0);
                join_none
            end
        end
        wait fork;
        repeat (3) @(negedge clk);
        #1;
        chk(log_n - base == cnt, "R7 transaction count", log_n - base, cnt);
        chk(!s_awvalid && m_awready == 0 && !s_bready, "R7 back to idle",
            {s_awvalid, m_awready, s_bready}, 0);
        taken = '0;
        for (int p = 0; p < cnt; p++) begin
            int best;
            best = -1;
            for (int j = 0; j < N; j++)
                if (mask[j] && !taken[j] && (best < 0 || LEN[j] < LEN[best])) best = j;
            taken[best] = 1'b1;
            chk(log_id[base+p] == best, (mask == 4'hF) ? "R4 full order" : "R3 order",
                log_id[base+p], best);
            if (p == 0)
                chk(log_aw[base] - raise_cyc[best] == 1, "R10 idle latency",
                    log_aw[base] - raise_cyc[best], 1);
            else
                chk(log_aw[base+p] == log_b[base+p-1] + 1, "R7 handover",
                    log_aw[base+p] - log_b[base+p-1], 1);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            awv[i] = 0; awa[i] = 0; awl[i] = 0; wv[i] = 0; wd[i] = 0; wl[i] = 0; bry[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(!s_awvalid && !s_wvalid && !s_bready && m_awready == 0 && m_wready == 0 &&
            m_bvalid == 0, "R1 reset quiet", {s_awvalid, s_wvalid, s_bready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!s_awvalid && m_awready == 0 && m_wready == 0 && m_bvalid == 0,
            "R1 after release", {s_awvalid, m_awready}, 0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            #1;
            chk(!s_awvalid && !s_wvalid && m_awready == 0 && log_n == 0, "R2 idle no forward",
                {s_awvalid, s_wvalid, m_awready}, 0);
        end

        // R4 then R3: every non-empty set of simultaneous requesters
        run_set(4'hF);
        for (int m = 1; m < 16; m++) run_set(4'(m));

        // R5: master 3 (highest rank) arrives during master 0's long burst
        begin
            int base;
            base = log_n;
            @(negedge clk);
            fork
                run_master(0, 1'b0);
                begin
                    repeat (4) @(negedge clk);
                    run_master(3, 1'b0);
                end
            join
            chk(log_id[base] == 0 && log_id[base+1] == 3, "R5 no preemption",
                log_id[base+1], 3);
            chk(log_aw[base+1] == log_b[base] + 1, "R5 waits for response",
                log_aw[base+1] - log_b[base], 1);
        end

        // R8: master 2 keeps AWVALID high during its own data beats
        @(negedge clk);
        run_master(2, 1'b1);
        repeat (3) @(negedge clk);

        chk(r9_err == 0 && r9_n > 0, "R9 address and data routing", r9_err, 0);
        chk(r6_err == 0 && r6_n > 0, "R6 back-pressure to non-owners", r6_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule